// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block holds a page-sized staging buffer in front of a byte-wide storage array and sequences the commit of that buffer into the array. A protocol engine first loads a start address. The upper address bits select the page, which is latched. The lower bits set the starting byte offset. The engine then streams data bytes. Each byte lands in the buffer at the current offset, sets that offset's valid bit, and advances the offset. The offset wraps inside the page and never carries into the page number.

A commit request copies every valid buffer byte into the array in a single write step. A busy flag stays high for a programmable number of clock cycles to model the slow internal write. While busy is high, load, commit and read requests are dropped. When the timed cycle finishes, the valid mask clears and a new session can begin. A separate read port returns one array byte per request with one cycle of latency. The array starts out with every location at FFh.

Top module: `page_commit_store`

## Requirements
- R1: After reset, every array location reads FFh and `busy_o` is low.
- R2: A load-address request latches the page from `addr_i[11:5]` and the offset from `addr_i[4:0]`. Each accepted load-byte request places `byte_i` at array address page*32 + offset when it is committed.
- R3: Each accepted byte advances the 5-bit offset by one. After offset 31 the offset wraps to 0 in the same page, and the page number is not incremented.
- R4: A byte loaded at an offset that already holds a byte in the same session replaces the earlier value, so the last value wins.
- R5: An accepted commit writes all loaded bytes into the array in one step. `busy_o` rises on the edge that accepts the commit and stays high for exactly max(`wr_cycles_i`, 1) cycles.
- R6: Array locations in the latched page whose offsets were not loaded in the session keep their previous contents after the commit.
- R7: Load-address, load-byte and commit requests that arrive while `busy_o` is high are ignored. This includes a commit, which does not extend the busy window.
- R8: The valid mask clears when a commit completes. Bytes from an earlier session are therefore never written again by a later commit, even to a different page.
- R9: A read request accepted while `busy_o` is low returns the array byte on `rd_data_o` with `rd_valid_o` high one cycle later. A read request made while `busy_o` is high gets no response, and `rd_valid_o` stays low.
- R10: If requests coincide, the priority is commit first, then load-address, then load-byte. Only the highest-priority request takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_addr_i | input | 1 | Load start address request |
| addr_i | input | 12 | Start address (page and offset) |
| ld_byte_i | input | 1 | Load data byte request |
| byte_i | input | 8 | Data byte |
| commit_i | input | 1 | Commit buffered bytes to array |
| wr_cycles_i | input | 16 | Length of the timed write cycle in clocks (0 behaves as 1) |
| rd_req_i | input | 1 | Read request |
| rd_addr_i | input | 12 | Read address |
| rd_data_o | output | 8 | Read data |
| rd_valid_o | output | 1 | Read data valid, one cycle after request |
| busy_o | output | 1 | Timed write cycle in progress |

## Verification
The hardest situation to reach is a stale valid mask. The buffer still holds the data of the previous session, so rewriting it to the same page leaves the array unchanged and the fault stays hidden. The stimulus therefore commits one byte in one page. It then loads the next offset in a different page with no intervening reset and commits again, and finally reads back offset 0 of the second page, which must still be FFh. A second difficulty is proving that requests made during busy are dropped. This is handled by issuing address, byte, commit and read requests inside a long busy window. The bench then checks that the window length is unchanged, that no read response appears, and that neither stray value reaches the array.

// File: rtl/pcs_pkg.sv
`timescale 1ns/1ps
package pcs_pkg;
  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_ADDR = 2'd1,
    REQ_BYTE = 2'd2
  } buf_req_e;
endpackage

// File: rtl/pcs_wr_timer.sv
`timescale 1ns/1ps
module pcs_wr_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] cycles_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= (cycles_i == '0) ? '0 : cycles_i - 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o); // R5
  AST_DONE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o); // R5
  AST_START_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o); // R5
endmodule

// File: rtl/pcs_page_buf.sv
`timescale 1ns/1ps
module pcs_page_buf
  import pcs_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32,
  localparam int OFS_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - OFS_W
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  buf_req_e                             req_i,
  input  logic [ADDR_W-1:0]                    addr_i,
  input  logic [DATA_W-1:0]                    byte_i,
  input  logic                                 done_i,
  output logic [PAGE_W-1:0]                    page_o,
  output logic [PAGE_BYTES-1:0][DATA_W-1:0]    data_o,
  output logic [PAGE_BYTES-1:0]                valid_o
);
  logic [OFS_W-1:0]                 ofs_q;
  logic [PAGE_W-1:0]                page_q;
  logic [PAGE_BYTES-1:0][DATA_W-1:0] data_q;
  logic [PAGE_BYTES-1:0]            valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ofs_q   <= '0;
      page_q  <= '0;
      data_q  <= '0;
      valid_q <= '0;
    end else if (done_i) begin
      valid_q <= '0;
    end else begin
      case (req_i)
        REQ_ADDR: begin
          page_q <= addr_i[ADDR_W-1:OFS_W];
          ofs_q  <= addr_i[OFS_W-1:0];
        end
        REQ_BYTE: begin
          data_q[ofs_q]  <= byte_i;
          valid_q[ofs_q] <= 1'b1;
          ofs_q          <= ofs_q + 1'b1; // wraps inside page
        end
        default: ;
      endcase
    end
  end

  assign page_o  = page_q;
  assign data_o  = data_q;
  assign valid_o = valid_q;

  AST_OFS_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i && req_i == REQ_BYTE && ofs_q == '1 |=> ofs_q == '0 && $stable(page_q)); // R3
  AST_BYTE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i && req_i == REQ_BYTE |=> valid_q[$past(ofs_q)]); // R2
  AST_MASK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> valid_o == '0); // R8
endmodule

// File: rtl/pcs_store.sv
`timescale 1ns/1ps
module pcs_store #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32,
  localparam int OFS_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - OFS_W,
  localparam int DEPTH     = 1 << ADDR_W
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_i,
  input  logic [PAGE_W-1:0]                 page_i,
  input  logic [PAGE_BYTES-1:0][DATA_W-1:0] data_i,
  input  logic [PAGE_BYTES-1:0]             valid_i,
  input  logic                              rd_en_i,
  input  logic [ADDR_W-1:0]                 rd_addr_i,
  output logic [DATA_W-1:0]                 rd_data_o,
  output logic                              rd_valid_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  // erased state is all ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (wr_i) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (valid_i[i]) mem_q[{page_i, OFS_W'(i)}] <= data_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= mem_q[rd_addr_i];
    end
  end

  AST_RD_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o); // R9
endmodule

// File: rtl/page_commit_store.sv
`timescale 1ns/1ps
module page_commit_store
  import pcs_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32,
  parameter int CNT_W      = 16,
  localparam int OFS_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_addr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ld_byte_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              commit_i,
  input  logic [CNT_W-1:0]  wr_cycles_i,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              busy_o
);
  buf_req_e                          req;
  logic                              start, done, rd_en;
  logic [PAGE_W-1:0]                 buf_page;
  logic [PAGE_BYTES-1:0][DATA_W-1:0] buf_data;
  logic [PAGE_BYTES-1:0]             buf_valid;

  // commit > address > byte; nothing accepted while busy
  always_comb begin
    req = REQ_NONE;
    if (!busy_o && !commit_i) begin
      if (ld_addr_i)      req = REQ_ADDR;
      else if (ld_byte_i) req = REQ_BYTE;
    end
  end

  assign start = commit_i && !busy_o;
  assign rd_en = rd_req_i && !busy_o;

  pcs_wr_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i, .rst_ni,
    .start_i  (start),
    .cycles_i (wr_cycles_i),
    .busy_o   (busy_o),
    .done_o   (done)
  );

  pcs_page_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) i_buf (
    .clk_i, .rst_ni,
    .req_i   (req),
    .addr_i  (addr_i),
    .byte_i  (byte_i),
    .done_i  (done),
    .page_o  (buf_page),
    .data_o  (buf_data),
    .valid_o (buf_valid)
  );

  pcs_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) i_store (
    .clk_i, .rst_ni,
    .wr_i       (done),
    .page_i     (buf_page),
    .data_i     (buf_data),
    .valid_i    (buf_valid),
    .rd_en_i    (rd_en),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o)
  );

  AST_RD_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !rd_valid_o); // R9
  AST_LOAD_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done |=> $stable(buf_valid) && $stable(buf_page) && $stable(buf_data)); // R7
  AST_COMMIT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && !busy_o |=> $stable(buf_valid) && $stable(buf_page)); // R10
endmodule

// File: tb/test_page_commit_store.sv
`timescale 1ns/1ps
module test_page_commit_store;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ld_addr_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic        ld_byte_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        commit_i = 1'b0;
  logic [15:0] wr_cycles_i = 16'd1;
  logic        rd_req_i = 1'b0;
  logic [11:0] rd_addr_i = '0;
  logic [7:0]  rd_data_o;
  logic        rd_valid_o;
  logic        busy_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  page_commit_store i_page_commit_store (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_addr(logic [11:0] a);
    @(negedge clk_i); ld_addr_i = 1'b1; addr_i = a;
    @(posedge clk_i); #1 ld_addr_i = 1'b0;
  endtask

  task automatic load_byte(logic [7:0] b);
    @(negedge clk_i); ld_byte_i = 1'b1; byte_i = b;
    @(posedge clk_i); #1 ld_byte_i = 1'b0;
  endtask

  // commit and measure busy length
  task automatic commit_n(string req, int n, int exp_len);
    int len = 0;
    @(negedge clk_i); wr_cycles_i = 16'(n); commit_i = 1'b1;
    @(posedge clk_i); #1 commit_i = 1'b0;
    while (busy_o) begin
      len++;
      @(posedge clk_i); #1;
    end
    chk(req, len, exp_len);
  endtask

  task automatic read_chk(string req, logic [11:0] a, int exp);
    @(negedge clk_i); rd_req_i = 1'b1; rd_addr_i = a;
    @(posedge clk_i); #1 rd_req_i = 1'b0;
    chk({req, " valid"}, int'(rd_valid_o), 1);
    chk(req, int'(rd_data_o), exp);
  endtask

  task automatic t_reset;
    chk("R1 busy", int'(busy_o), 0);
    read_chk("R1 addr 000", 12'h000, 8'hff);
    read_chk("R1 addr fff", 12'hfff, 8'hff);
    read_chk("R1 addr 123", 12'h123, 8'hff);
  endtask

  task automatic t_single;
    load_addr(12'h123);
    load_byte(8'ha5);
    commit_n("R5 busy len 4", 4, 4);
    read_chk("R2 byte at 123", 12'h123, 8'ha5);
    read_chk("R6 neighbour 124", 12'h124, 8'hff);
    read_chk("R6 neighbour 122", 12'h122, 8'hff);
  endtask

  task automatic t_wrap;
    load_addr(12'h05e);
    load_byte(8'h11); load_byte(8'h22); load_byte(8'h33); load_byte(8'h44);
    commit_n("R5 busy len 2", 2, 2);
    read_chk("R3 ofs 30", 12'h05e, 8'h11);
    read_chk("R3 ofs 31", 12'h05f, 8'h22);
    read_chk("R3 wrap ofs 0", 12'h040, 8'h33);
    read_chk("R3 wrap ofs 1", 12'h041, 8'h44);
    read_chk("R3 next page untouched", 12'h060, 8'hff);
  endtask

  task automatic t_overwrite;
    load_addr(12'h200);
    for (int i = 0; i < 32; i++) load_byte(8'(8'h80 + i));
    load_byte(8'ha0);
    commit_n("R5 busy len 3", 3, 3);
    read_chk("R4 overwritten ofs 0", 12'h200, 8'ha0);
    read_chk("R5 full page ofs 1", 12'h201, 8'h81);
    read_chk("R5 full page ofs 31", 12'h21f, 8'h9f);
  endtask

  task automatic t_busy_ignore;
    int len;
    load_addr(12'h300);
    load_byte(8'h5a);
    @(negedge clk_i); wr_cycles_i = 16'd20; commit_i = 1'b1;
    @(posedge clk_i); #1 commit_i = 1'b0;
    chk("R5 busy rises", int'(busy_o), 1);
    load_addr(12'h400);
    load_byte(8'h77);
    @(negedge clk_i); wr_cycles_i = 16'd50; commit_i = 1'b1;
    @(posedge clk_i); #1 commit_i = 1'b0;
    @(negedge clk_i); rd_req_i = 1'b1; rd_addr_i = 12'h300;
    @(posedge clk_i); #1 rd_req_i = 1'b0;
    chk("R9 no read while busy", int'(rd_valid_o), 0);
    len = 4;
    while (busy_o) begin
      len++;
      @(posedge clk_i); #1;
    end
    chk("R7 busy len unchanged", len, 20);
    read_chk("R7 committed 300", 12'h300, 8'h5a);
    read_chk("R7 ignored addr 400", 12'h400, 8'hff);
    read_chk("R7 ignored byte 301", 12'h301, 8'hff);
  endtask

  task automatic t_mask_clear;
    load_addr(12'h340);
    load_byte(8'h5a);
    commit_n("R5 busy len 2b", 2, 2);
    load_addr(12'h361);
    load_byte(8'h22);
    commit_n("R5 zero cycles acts as 1", 0, 1);
    read_chk("R8 stale byte not rewritten", 12'h360, 8'hff);
    read_chk("R8 new byte", 12'h361, 8'h22);
    read_chk("R8 first session kept", 12'h340, 8'h5a);
  endtask

  task automatic t_priority;
    load_addr(12'h500);
    @(negedge clk_i); ld_addr_i = 1'b1; addr_i = 12'h600; ld_byte_i = 1'b1; byte_i = 8'h99;
    @(posedge clk_i); #1 ld_addr_i = 1'b0; ld_byte_i = 1'b0;
    load_byte(8'h3c);
    @(negedge clk_i); wr_cycles_i = 16'd2; commit_i = 1'b1; ld_byte_i = 1'b1; byte_i = 8'hee;
    @(posedge clk_i); #1 commit_i = 1'b0; ld_byte_i = 1'b0;
    while (busy_o) begin @(posedge clk_i); #1; end
    read_chk("R10 addr beats byte", 12'h600, 8'h3c);
    read_chk("R10 old page untouched", 12'h500, 8'hff);
    read_chk("R10 commit beats byte", 12'h601, 8'hff);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    t_reset();
    t_single();
    t_wrap();
    t_overwrite();
    t_busy_ignore();
    t_mask_clear();
    t_priority();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule